// File: doc/BRIEF.md
# Scaled Fixed-Point Seven-Segment Readout

This block drives an eight-position, common-anode seven-segment display from a signed binary number that carries a value multiplied by ten thousand. It shows a sign position, two integer digits, a fixed decimal point, and four fractional digits. The input 256365 therefore appears as `25.6365`, and -12345 appears as `-01.2345`. Seven positions are in use. The leftmost of the eight positions is never lit.

The block converts the input to decimal itself. It takes the magnitude, runs a sequential shift-and-add-3 conversion, and places the result in a display frame. That frame is replaced in a single clock cycle, and only when a conversion has finished. The input is sampled at the start of each conversion, and conversions run back to back. The positions are scanned one at a time, and each stays lit for a programmable number of clock cycles. Magnitudes beyond 99.9999 show dashes on every used position.

Top module: `scaled_temp_display`

## Requirements
- R1: The segment bus `seg_n[6:0]` is active low, with bit 0 = segment a through bit 6 = segment g. Position 0 (rightmost) shows the 10^-4 digit of the magnitude, positions 1 to 3 show the next fractional digits, position 4 shows the units digit, and position 5 shows the tens digit. Leading zeros are shown.
- R2: `dp_n` is low only while position 4 is lit and the value is in range. It is high on every other position.
- R3: Position 6 shows a minus sign (segment g only, `seg_n` = 7'b0111111) for a negative in-range input, and is blank (`seg_n` = 7'b1111111) otherwise.
- R4: If the magnitude exceeds 999999, positions 0 to 6 all show the minus pattern and `dp_n` stays high. Magnitudes of exactly 999999 are shown normally.
- R5: At most one bit of `an_n` is low at any time, and `an_n[7]` never goes low. Positions are visited in the order 0, 1, …, 7, and each slot lasts REFRESH_DIV cycles. Slot 7 is dark, with all anodes high.
- R6: While `rst_n` is low, all anodes are high. After reset, until the first conversion completes, every lit position is blank with `dp_n` high.
- R7: The displayed frame changes only in the cycle that completes a conversion, and all positions change together. An input held stable is shown no later than 2*(IN_W+2)+3 cycles after it was applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| value_in | input | IN_W | Signed two's-complement value times 10^4 |
| seg_n | output | 7 | Active-low segments a..g (bit 0 = a) |
| dp_n | output | 1 | Active-low decimal point |
| an_n | output | 8 | Active-low anodes, bit 0 = rightmost position |

## Verification
The embedded assertions check the scan on every cycle: at most one anode is active, the dark eighth slot, single-step advance on each refresh tick, and the decimal point only on the units position. They also check, cycle by cycle, that every converted digit is legal BCD, that the frame moves only on a commit, and that sign and overflow patterns land in the frame. Whether the digits shown actually match the decimal form of the input can be shown only by the bench. It compares each lit position against a separately computed rendering over random and boundary values (±999999, ±1000000, the most negative input, values with leading zeros), and it also covers slot length and the blank frame after reset.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;

  localparam int unsigned BCD_DIGITS = 6;

  localparam logic [6:0] SEG_BLANK_N = 7'b1111111;
  localparam logic [6:0] SEG_DASH_N  = 7'b0111111;

  typedef enum logic [1:0] {
    CV_LOAD   = 2'd0,
    CV_SHIFT  = 2'd1,
    CV_COMMIT = 2'd2
  } conv_state_e;

  // Active-low pattern, bit 0 = segment a, bit 6 = segment g
  function automatic logic [6:0] digit_to_seg_n(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0:    s = 7'b1000000;
      4'd1:    s = 7'b1111001;
      4'd2:    s = 7'b0100100;
      4'd3:    s = 7'b0110000;
      4'd4:    s = 7'b0011001;
      4'd5:    s = 7'b0010010;
      4'd6:    s = 7'b0000010;
      4'd7:    s = 7'b1111000;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0010000;
      default: s = SEG_DASH_N;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/refresh_tick.sv
module refresh_tick #(
  parameter int unsigned DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0))
    else $error("refresh counter did not restart after tick");

endmodule

// File: rtl/bcd_converter.sv
module bcd_converter #(
  parameter int unsigned MAG_W  = 24,
  parameter int unsigned DIGITS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MAG_W-1:0]      mag_in,
  output logic                  sample,
  output logic                  commit,
  output logic [4*DIGITS-1:0]   bcd
);
  import segdisp_pkg::*;

  localparam int unsigned BCD_W = 4 * DIGITS;
  localparam int unsigned CNT_W = $clog2(MAG_W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MAG_W - 1);

  conv_state_e          st_q, st_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [MAG_W-1:0]     sh_q, sh_d;
  logic [BCD_W-1:0]     bcd_q, bcd_d;
  logic [BCD_W-1:0]     adj;

  // add-3 correction on every nibble before the shift
  for (genvar i = 0; i < DIGITS; i++) begin : g_adj
    always_comb begin
      if (bcd_q[4*i +: 4] >= 4'd5) adj[4*i +: 4] = bcd_q[4*i +: 4] + 4'd3;
      else                         adj[4*i +: 4] = bcd_q[4*i +: 4];
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    bcd_d = bcd_q;
    case (st_q)
      CV_LOAD: begin
        sh_d  = mag_in;
        bcd_d = '0;
        cnt_d = '0;
        st_d  = CV_SHIFT;
      end
      CV_SHIFT: begin
        {bcd_d, sh_d} = {adj, sh_q} << 1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) st_d = CV_COMMIT;
      end
      CV_COMMIT: begin
        st_d = CV_LOAD;
      end
      default: st_d = CV_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CV_LOAD;
      cnt_q <= '0;
      sh_q  <= '0;
      bcd_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      bcd_q <= bcd_d;
    end
  end

  assign sample = (st_q == CV_LOAD);
  assign commit = (st_q == CV_COMMIT);
  assign bcd    = bcd_q;

  for (genvar i = 0; i < DIGITS; i++) begin : g_chk
    p_bcd_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (bcd_q[4*i +: 4] <= 4'd9))
      else $error("non-decimal nibble at commit");
  end

  p_step_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CV_SHIFT && cnt_q != LAST_STEP) |=> (st_q == CV_SHIFT))
    else $error("conversion left shift phase early");

endmodule

// File: rtl/scan_driver.sv
module scan_driver #(
  parameter int unsigned NUM_POS = 8,
  parameter int unsigned USED    = 7,
  parameter int unsigned DP_POS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [USED-1:0][7:0]    frame,
  output logic [6:0]              seg_n,
  output logic                    dp_n,
  output logic [NUM_POS-1:0]      an_n
);
  import segdisp_pkg::*;

  localparam int unsigned POS_W = $clog2(NUM_POS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_POS - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_used;

  always_comb begin
    pos_d = pos_q;
    if (tick) begin
      if (pos_q == LAST_POS) pos_d = '0;
      else                   pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos_used = (32'(pos_q) < USED);

  always_comb begin
    an_n  = '1;
    seg_n = SEG_BLANK_N;
    dp_n  = 1'b1;
    if (rst_n && pos_used) begin
      an_n[pos_q] = 1'b0;
      seg_n       = frame[pos_q][6:0];
      dp_n        = frame[pos_q][7];
    end
  end

  p_one_anode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~an_n))
    else $error("more than one anode active");

  p_dark_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    an_n[NUM_POS-1])
    else $error("unused position lit");

  p_scan_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pos_q != LAST_POS) |=> (pos_q == $past(pos_q) + 1'b1))
    else $error("scan did not advance by one");

  p_scan_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos_q))
    else $error("scan moved without tick");

  p_dp_units_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_n |-> !an_n[DP_POS])
    else $error("decimal point outside units position");

endmodule

// File: rtl/scaled_temp_display.sv
module scaled_temp_display #(
  parameter int unsigned IN_W        = 24,
  parameter int unsigned REFRESH_DIV = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  value_in,
  output logic [6:0]       seg_n,
  output logic             dp_n,
  output logic [7:0]       an_n
);
  import segdisp_pkg::*;

  localparam int unsigned NUM_POS  = 8;
  localparam int unsigned USED     = 7;
  localparam int unsigned SIGN_POS = USED - 1;
  localparam int unsigned DP_POS   = 4;
  localparam logic [IN_W-1:0] MAX_MAG = IN_W'(999999);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // sign / magnitude / range of the incoming sample
  logic            in_neg;
  logic [IN_W-1:0] in_mag;
  logic            in_ovf;

  assign in_neg = value_in[IN_W-1];
  assign in_mag = in_neg ? (~value_in + 1'b1) : value_in;
  assign in_ovf = (in_mag > MAX_MAG);

  logic                      conv_sample, conv_commit;
  logic [4*BCD_DIGITS-1:0]   conv_bcd;

  bcd_converter #(
    .MAG_W  (IN_W),
    .DIGITS (BCD_DIGITS)
  ) u_conv (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mag_in (in_mag),
    .sample (conv_sample),
    .commit (conv_commit),
    .bcd    (conv_bcd)
  );

  // flags captured with the sample, used at commit
  logic pend_neg_q, pend_ovf_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_neg_q <= 1'b0;
      pend_ovf_q <= 1'b0;
    end else if (conv_sample) begin
      pend_neg_q <= in_neg;
      pend_ovf_q <= in_ovf;
    end
  end

  // next frame: {dp_n, seg_n} per position
  logic [USED-1:0][7:0] frame_q, frame_d;

  for (genvar p = 0; p < BCD_DIGITS; p++) begin : g_digit
    localparam logic DP_BIT = (p == DP_POS) ? 1'b0 : 1'b1;
    always_comb begin
      if (pend_ovf_q) frame_d[p] = {1'b1, SEG_DASH_N};
      else            frame_d[p] = {DP_BIT, digit_to_seg_n(conv_bcd[4*p +: 4])};
    end
  end

  always_comb begin
    if (pend_ovf_q || pend_neg_q) frame_d[SIGN_POS] = {1'b1, SEG_DASH_N};
    else                          frame_d[SIGN_POS] = {1'b1, SEG_BLANK_N};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      frame_q <= {USED{{1'b1, SEG_BLANK_N}}};
    else if (conv_commit) frame_q <= frame_d;
  end

  logic refresh;

  refresh_tick #(
    .DIV (REFRESH_DIV)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (refresh)
  );

  scan_driver #(
    .NUM_POS (NUM_POS),
    .USED    (USED),
    .DP_POS  (DP_POS)
  ) u_scan (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (refresh),
    .frame (frame_q),
    .seg_n (seg_n),
    .dp_n  (dp_n),
    .an_n  (an_n)
  );

  p_frame_atomic_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !conv_commit |=> $stable(frame_q))
    else $error("frame changed outside commit");

  p_overflow_dash_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (conv_commit && pend_ovf_q) |=>
      (frame_q[0][6:0] == SEG_DASH_N && frame_q[DP_POS][7]))
    else $error("overflow frame lacks dashes");

  p_minus_sign_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (conv_commit && pend_neg_q) |=> (frame_q[SIGN_POS][6:0] == SEG_DASH_N))
    else $error("negative value without minus sign");

  p_reset_dark_r6: assert property (@(posedge clk)
    !rst_sync_n |-> (an_n == '1))
    else $error("anode active during reset");

endmodule

// File: tb/scaled_temp_display_bench.sv
module scaled_temp_display_bench;

  localparam int unsigned IN_W = 24;
  localparam int unsigned DIV  = 4;
  localparam int unsigned SETTLE = 2 * (IN_W + 2) + 3;

  logic            clk;
  logic            rst_n;
  logic [IN_W-1:0] value_in;
  logic [6:0]      seg_n;
  logic            dp_n;
  logic [7:0]      an_n;

  int n_checks;
  int n_fail;
  bit finished;

  scaled_temp_display #(
    .IN_W        (IN_W),
    .REFRESH_DIV (DIV)
  ) u_scaled_temp_display (
    .clk      (clk),
    .rst_n    (rst_n),
    .value_in (value_in),
    .seg_n    (seg_n),
    .dp_n     (dp_n),
    .an_n     (an_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // active-high a..g, inverted on return
  function automatic logic [6:0] ref_digit(input int d);
    logic [6:0] hi;
    case (d)
      0: hi = 7'h3F; 1: hi = 7'h06; 2: hi = 7'h5B; 3: hi = 7'h4F; 4: hi = 7'h66;
      5: hi = 7'h6D; 6: hi = 7'h7D; 7: hi = 7'h07; 8: hi = 7'h7F; default: hi = 7'h6F;
    endcase
    return ~hi;
  endfunction

  function automatic logic [7:0] ref_pos(input int v, input int p);
    int  mag;
    int  sc;
    bit  ovf;
    mag = (v < 0) ? -v : v;
    ovf = (mag > 999999);
    if (p == 6) return (ovf || v < 0) ? 8'b1_0111111 : 8'b1_1111111;
    if (ovf) return 8'b1_0111111;
    sc = 1;
    for (int k = 0; k < p; k++) sc = sc * 10;
    return {(p == 4) ? 1'b0 : 1'b1, ref_digit((mag / sc) % 10)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic show_and_check(input int v);
    int guard;
    int slot;
    value_in = IN_W'(v);
    repeat (SETTLE) @(negedge clk);
    for (int p = 0; p < 7; p++) begin
      guard = 0;
      while (an_n != ~(8'd1 << p) && guard < 16 * DIV) begin
        @(negedge clk);
        guard++;
      end
      // R1 R2 R3 R4 digit, point, sign, overflow per position
      check(an_n == ~(8'd1 << p), "R5", 32'(an_n), 32'(~(8'd1 << p)), "anode reach");
      check({dp_n, seg_n} == ref_pos(v, p),
            (p == 6) ? "R3" : ((v > 999999 || v < -999999) ? "R4" : (p == 4 ? "R2" : "R1")),
            32'({dp_n, seg_n}), 32'(ref_pos(v, p)), $sformatf("value %0d pos %0d", v, p));
    end
    slot = 0;
    while (an_n == 8'b1011_1111) begin
      @(negedge clk);
      slot++;
    end
    check(slot == DIV, "R5", 32'(slot), 32'(DIV), "slot length");
    check(an_n == 8'hFF, "R5", 32'(an_n), 32'hFF, "dark eighth slot");
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    value_in = IN_W'(256365);
    repeat (4) @(negedge clk);
    check(an_n == 8'hFF, "R6", 32'(an_n), 32'hFF, "anodes during reset");
    rst_n = 1'b1;
    // before the first commit (~IN_W+4 cycles): lit positions blank
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (an_n != 8'hFF)
        check(seg_n == 7'h7F && dp_n, "R6", 32'({dp_n, seg_n}), 32'hFF, "blank before commit");
    end
    // directed corners
    show_and_check(256365);
    show_and_check(-256365);
    show_and_check(0);
    show_and_check(50000);
    show_and_check(999999);
    show_and_check(-999999);
    show_and_check(1000000);
    show_and_check(-1000000);
    show_and_check(-(1 << (IN_W - 1)));
    show_and_check((1 << (IN_W - 1)) - 1);
    show_and_check(-1);
    // R7: change mid conversion, final value must win
    value_in = IN_W'(123456);
    repeat (7) @(negedge clk);
    show_and_check(-87654);
    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 40; i++) begin
      int v;
      v = int'($urandom % 32'd2400001) - 1200000;
      show_and_check(v);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule